// File: doc/BRIEF.md
# Clock Output Mode and Gating Controller

This block is the digital control core of a multi-output system clock generator. It receives three free-running source clocks: a crystal-derived reference, a synthesized processor-rate clock and a fixed 48 MHz clock. From these it produces one group of processor clock lines, one group of bus clock lines at half the processor rate, a group of reference lines, one interrupt-controller (IOAPIC) reference line and a pair of 48 MHz lines. A two-bit frequency select picks the operating mode. In one mode every line is released to high impedance. Two modes pass the synthesized clock, whose 60 or 66.6 MHz rate the external synthesizer chooses. The last is a test mode in which every group is derived from the reference alone.

Separate active-high run inputs stop the processor group and the bus group in the low state, one independently of the other. An active-low power-down input stops every group low. Each stop and each restart waits for the low phase of the affected clock, so no line ever shows a shortened high or low pulse. The pads themselves are outside the block: it drives clock values and a single output-enable that the pad ring uses for tristate. Pull-ups on the control pins also live in the pad ring.

The frequency select is a strap input. It is changed only while `rst_n` is low, and `rst_n` is held low for several cycles of every source clock.

Top module: `clkout_ctrl`

## Requirements
- R1: `out_en` is low when `fsel` is 2'b00 and `pwr_n` is high. It is high for any other `fsel` value and whenever `pwr_n` is low.
- R2: With `fsel` 2'b01 or 2'b10, the processor lines repeat at the period of `clk_cpu`, the reference and IOAPIC lines at the period of `clk_ref`, and the 48 MHz lines at the period of `clk_48`.
- R3: The bus lines toggle at half the processor-line rate. Every rising edge of a bus line falls at the same instant as a rising edge of the processor lines.
- R4: With `fsel` 2'b11, the processor lines run at `clk_ref`/2, the bus lines at `clk_ref`/4, the reference and IOAPIC lines at `clk_ref`, and the 48 MHz lines at `clk_ref`/2.
- R5: While `cpu_run` is low, every processor line stays low within four source cycles and the bus lines keep running.
- R6: While `bus_run` is low, every bus line stays low within a few source cycles and the processor lines keep running.
- R7: While `pwr_n` is low, every output line (processor, bus, reference, IOAPIC, 48 MHz) stays low within four cycles of its own source.
- R8: Across any change of `cpu_run`, `bus_run` or `pwr_n`, no output line shows a high or low pulse shorter than half its running period in the current mode.
- R9: All lines of a group always carry the same value.
- R10: While `rst_n` is low, every output line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Synthesized processor-rate source clock |
| clk_ref | input | 1 | Crystal-derived reference clock |
| clk_48 | input | 1 | Fixed 48 MHz source clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in each source domain |
| fsel | input | 2 | Mode select: 00 high impedance, 01 and 10 normal, 11 reference test |
| cpu_run | input | 1 | High lets the processor group run, low stops it low |
| bus_run | input | 1 | High lets the bus group run, low stops it low |
| pwr_n | input | 1 | Low stops every group low |
| cpu_clk | output | NCPU | Processor clock lines |
| bus_clk | output | NBUS | Bus clock lines |
| ref_clk | output | NREF | Reference clock lines |
| apic_clk | output | 1 | IOAPIC reference line |
| usb_clk | output | NUSB | 48 MHz lines |
| out_en | output | 1 | Pad drive enable; low means high impedance |

## Verification
The hardest case to reach from the ports is a run or power-down input that changes while a clock line is high, or just before its rising edge. In that case a careless gate would clip a pulse. The stimulus reaches it with bursts of toggles on each control input. The gaps grow by a non-integer step, so over a burst the change lands at many phases of every source clock. A width monitor on each group records the shortest high and low pulse seen since reset, and that minimum is compared with the half period of the mode. Bus-to-processor rising-edge coincidence is checked in steady windows of both the normal mode and the test mode.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the clock output controller.
// Assumes nothing beyond IEEE 1800-2017.
package clkout_pkg;

    // Mode select encoding; the values are the pin encoding.
    typedef enum logic [1:0] {
        FS_HIZ  = 2'b00,
        FS_LOW  = 2'b01,
        FS_HIGH = 2'b10,
        FS_TEST = 2'b11
    } fsel_e;

    // Division ratio of a gated divider relative to its source clock.
    typedef enum logic {
        DIV_BY2 = 1'b0,
        DIV_BY4 = 1'b1
    } ratio_e;

endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
// Module: clkout_sync
// Multi-stage synchronizer that brings an asynchronous level into the
// domain of clk. Assumes STAGES >= 2 and a level input that changes
// slowly compared with clk.
module clkout_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    // Shift the level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/clkout_pass_gate.sv
`timescale 1ns/1ps
// Module: clkout_pass_gate
// Passes clk through undivided while run is high, and holds the output low
// otherwise. The run level is synchronized on rising edges and taken into
// the gate register on falling edges, so the enable changes only while clk
// is low and no pulse is clipped. Assumes clk keeps running during reset.
module clkout_pass_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk
);

    logic run_s;
    logic en_q;

    clkout_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run),
        .q     (run_s)
    );

    // Capture the enable in the low phase of clk.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= run_s;
    end

    assign gclk = clk & en_q;

    // R8: the gate register must track the synchronized level one half cycle later.
    a_r8_gate_tracks_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (en_q == run_s));

endmodule

// File: rtl/clkout_pattern.sv
`timescale 1ns/1ps
// Module: clkout_pattern
// Gated clock divider driven from a shared phase counter. The output follows
// a divide-by-2 or divide-by-4 pattern of the phase. A pulse may start only
// at the start of its pattern and only while run is high. A pulse that has
// started always runs to its normal end. Assumes ph is a free-running
// counter in the clk domain that counts up by one per cycle.
module clkout_pattern
    import clkout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  ratio_e     ratio,
    input  logic [1:0] ph,
    output logic       q
);

    logic       run_s;
    logic [1:0] ph_nxt;
    logic       pat_hi;
    logic       pat_start;

    clkout_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run),
        .q     (run_s)
    );

    // Decode the pattern level and start point for the coming cycle.
    always_comb begin
        ph_nxt = ph + 2'd1;
        if (ratio == DIV_BY4) begin
            pat_hi    = ~ph_nxt[1];
            pat_start = (ph_nxt == 2'b00);
        end else begin
            pat_hi    = ~ph_nxt[0];
            pat_start = ~ph_nxt[0];
        end
    end

    // Continue a running pulse, or start a new one when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= pat_hi & (q | (run_s & pat_start));
    end

    // R8: a divide-by-4 pulse is never cut to a single source cycle.
    a_r8_div4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == DIV_BY4 && $rose(q)) |=> q);

    // R8: a divide-by-2 pulse lasts exactly one source cycle.
    a_r8_div2_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == DIV_BY2 && q) |=> !q);

    // R3: rising edges line up with the shared phase origin.
    a_r3_rise_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> ((ratio == DIV_BY4) ? (ph == 2'b00) : !ph[0]));

endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/1ps
// Module: clkout_ctrl (top)
// Mode selection, division and glitch-free low-state gating for the
// processor, bus, reference, IOAPIC and 48 MHz clock groups of a system clock
// generator. Assumes fsel changes only while rst_n is low, and rst_n is held
// for several cycles of every source clock.
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int NCPU        = 4,
    parameter int NBUS        = 8,
    parameter int NREF        = 3,
    parameter int NUSB        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_cpu,
    input  logic            clk_ref,
    input  logic            clk_48,
    input  logic            rst_n,
    input  logic [1:0]      fsel,
    input  logic            cpu_run,
    input  logic            bus_run,
    input  logic            pwr_n,
    output logic [NCPU-1:0] cpu_clk,
    output logic [NBUS-1:0] bus_clk,
    output logic [NREF-1:0] ref_clk,
    output logic            apic_clk,
    output logic [NUSB-1:0] usb_clk,
    output logic            out_en
);

    logic       test_mode;
    logic       core_clk;
    logic [1:0] ph;
    logic       cpu_go, bus_go;
    ratio_e     bus_ratio;
    logic       cpu_pass, cpu_div, bus_g, ref_g, usb_pass, usb_div;
    logic       cpu_g, usb_g;

    // Select the core source and the per-group run levels.
    always_comb begin
        test_mode = (fsel == FS_TEST);
        core_clk  = test_mode ? clk_ref : clk_cpu;
        cpu_go    = cpu_run & pwr_n;
        bus_go    = bus_run & pwr_n;
        bus_ratio = test_mode ? DIV_BY4 : DIV_BY2;
    end

    // Shared phase counter that keeps all divided groups aligned.
    always_ff @(posedge core_clk) begin
        if (!rst_n) ph <= 2'b00;
        else        ph <= ph + 2'd1;
    end

    clkout_pass_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_pass (
        .clk (core_clk), .rst_n (rst_n), .run (cpu_go), .gclk (cpu_pass));

    clkout_pattern #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_div (
        .clk (core_clk), .rst_n (rst_n), .run (cpu_go), .ratio (DIV_BY2),
        .ph (ph), .q (cpu_div));

    clkout_pattern #(.SYNC_STAGES(SYNC_STAGES)) u_bus_div (
        .clk (core_clk), .rst_n (rst_n), .run (bus_go), .ratio (bus_ratio),
        .ph (ph), .q (bus_g));

    clkout_pass_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_pass (
        .clk (clk_ref), .rst_n (rst_n), .run (pwr_n), .gclk (ref_g));

    clkout_pass_gate #(.SYNC_STAGES(SYNC_STAGES)) u_usb_pass (
        .clk (clk_48), .rst_n (rst_n), .run (pwr_n), .gclk (usb_pass));

    clkout_pattern #(.SYNC_STAGES(SYNC_STAGES)) u_usb_div (
        .clk (core_clk), .rst_n (rst_n), .run (pwr_n), .ratio (DIV_BY2),
        .ph (ph), .q (usb_div));

    // Pick the undivided or divided variant per group for the mode.
    always_comb begin
        cpu_g  = test_mode ? cpu_div : cpu_pass;
        usb_g  = test_mode ? usb_div : usb_pass;
        out_en = (fsel != FS_HIZ) | ~pwr_n;
    end

    // Fan each group out to its lines.
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign cpu_clk[i] = cpu_g;
    end
    for (genvar i = 0; i < NBUS; i++) begin : g_bus
        assign bus_clk[i] = bus_g;
    end
    for (genvar i = 0; i < NREF; i++) begin : g_ref
        assign ref_clk[i] = ref_g;
    end
    for (genvar i = 0; i < NUSB; i++) begin : g_usb
        assign usb_clk[i] = usb_g;
    end
    assign apic_clk = ref_g;

    // R7: four reference low-phase samples of power-down leave the reference line low.
    a_r7_ref_low_in_pd: assert property (@(negedge clk_ref) disable iff (!rst_n)
        (!pwr_n && !$past(pwr_n) && !$past(pwr_n, 2) && !$past(pwr_n, 3)) |-> !ref_clk[0]);

endmodule

// File: tb/clkout_ctrl_tb.sv
`timescale 1ns/1ps
// Edge monitor: counts rising edges and keeps the shortest high and low widths.
module clkout_edge_mon (
    input logic sig,
    input logic clr
);
    realtime t_rise, t_fall, min_hi, min_lo;
    int      rises;
    bit      have_r, have_f;

    initial begin
        min_hi = 1.0e9; min_lo = 1.0e9; rises = 0; have_r = 0; have_f = 0;
        t_rise = 0; t_fall = 0;
    end

    always @(posedge clr) begin
        min_hi = 1.0e9; min_lo = 1.0e9; rises = 0; have_r = 0; have_f = 0;
    end

    always @(posedge sig) begin
        if (have_f && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime; have_r = 1; rises++;
    end

    always @(negedge sig) begin
        if (have_r && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        t_fall = $realtime; have_f = 1;
    end
endmodule

module clkout_ctrl_tb;
    localparam int NCPU = 4, NBUS = 8, NREF = 3, NUSB = 2;

    logic clk_cpu = 0, clk_ref = 0, clk_48 = 0;
    logic rst_n = 0;
    logic [1:0] fsel = 2'b01;
    logic cpu_run = 1, bus_run = 1, pwr_n = 1;
    logic [NCPU-1:0] cpu_clk;
    logic [NBUS-1:0] bus_clk;
    logic [NREF-1:0] ref_clk;
    logic apic_clk;
    logic [NUSB-1:0] usb_clk;
    logic out_en;
    logic clr = 0;

    int nchk = 0, nerr = 0;
    int grp_bad = 0, align_bad = 0;
    bit align_on = 0, done = 0;

    always #2 clk_cpu = ~clk_cpu;   // 250 MHz processor source
    always #7 clk_ref = ~clk_ref;
    always #5 clk_48  = ~clk_48;

    clkout_ctrl u_dut (
        .clk_cpu (clk_cpu), .clk_ref (clk_ref), .clk_48 (clk_48), .rst_n (rst_n),
        .fsel (fsel), .cpu_run (cpu_run), .bus_run (bus_run), .pwr_n (pwr_n),
        .cpu_clk (cpu_clk), .bus_clk (bus_clk), .ref_clk (ref_clk),
        .apic_clk (apic_clk), .usb_clk (usb_clk), .out_en (out_en));

    clkout_edge_mon m_cpu (.sig (cpu_clk[0]), .clr (clr));
    clkout_edge_mon m_bus (.sig (bus_clk[0]), .clr (clr));
    clkout_edge_mon m_ref (.sig (ref_clk[0]), .clr (clr));
    clkout_edge_mon m_usb (.sig (usb_clk[0]), .clr (clr));

    // Reference model sampler: group equality (R9) and bus/processor edge coincidence (R3).
    initial begin
        logic cpu_prev, bus_prev;
        cpu_prev = 0; bus_prev = 0;
        #0.1;
        forever begin
            #1;
            if (cpu_clk != {NCPU{cpu_clk[0]}} || bus_clk != {NBUS{bus_clk[0]}} ||
                ref_clk != {NREF{ref_clk[0]}} || usb_clk != {NUSB{usb_clk[0]}} ||
                apic_clk !== ref_clk[0])
                grp_bad++;
            if (align_on && bus_clk[0] && !bus_prev && !(cpu_clk[0] && !cpu_prev))
                align_bad++;
            cpu_prev = cpu_clk[0]; bus_prev = bus_clk[0];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic chk_rate(input string req, input string what, input int got, input real exp);
        chk((got >= exp - 1.0) && (got <= exp + 1.0), req, what, real'(got), exp);
    endtask

    task automatic all_low(input string req, input string what);
        chk(cpu_clk == 0 && bus_clk == 0 && ref_clk == 0 && apic_clk == 0 && usb_clk == 0,
            req, what, real'({cpu_clk, bus_clk, ref_clk, apic_clk, usb_clk}), 0.0);
    endtask

    // Reset into a mode, check the reset state (R10), then clear the monitors.
    task automatic enter_mode(input logic [1:0] m);
        #0.3 rst_n = 0; fsel = m;
        #120;
        all_low("R10", "outputs during reset");
        rst_n = 1;
        #200;
        clr = 1; #0.5 clr = 0;
    endtask

    // Rising-edge counts over a window compared with the expected rates.
    task automatic rates(input string req, input real win, input real pc, input real pb,
                         input real pr, input real pu);
        int c0, b0, r0, u0;
        c0 = m_cpu.rises; b0 = m_bus.rises; r0 = m_ref.rises; u0 = m_usb.rises;
        align_on = 1;
        #(win);
        align_on = 0;
        chk_rate(req, "processor edges", m_cpu.rises - c0, win / pc);
        chk_rate("R3", "bus edges", m_bus.rises - b0, win / pb);
        chk_rate(req, "reference edges", m_ref.rises - r0, win / pr);
        chk_rate(req, "48 MHz edges", m_usb.rises - u0, win / pu);
        chk(align_bad == 0, "R3", "bus rise without processor rise", real'(align_bad), 0.0);
        chk(out_en == 1'b1, "R1", "output enable in running mode", real'(out_en), 1.0);
    endtask

    // Stop tests for both groups and power-down, then toggle bursts at sweeping phases.
    task automatic stops(input real pc, input real pb);
        int c0, b0, r0, u0;
        cpu_run = 0; #150;
        c0 = m_cpu.rises; b0 = m_bus.rises;
        #200;
        chk(m_cpu.rises == c0 && cpu_clk == 0, "R5", "processor edges while stopped",
            real'(m_cpu.rises - c0), 0.0);
        chk_rate("R5", "bus edges while processor stopped", m_bus.rises - b0, 200.0 / pb);
        cpu_run = 1; #150;
        bus_run = 0; #150;
        c0 = m_cpu.rises; b0 = m_bus.rises;
        #200;
        chk(m_bus.rises == b0 && bus_clk == 0, "R6", "bus edges while stopped",
            real'(m_bus.rises - b0), 0.0);
        chk_rate("R6", "processor edges while bus stopped", m_cpu.rises - c0, 200.0 / pc);
        bus_run = 1; #150;
        pwr_n = 0; #150;
        c0 = m_cpu.rises; b0 = m_bus.rises; r0 = m_ref.rises; u0 = m_usb.rises;
        #200;
        chk(m_cpu.rises == c0 && m_bus.rises == b0 && m_ref.rises == r0 && m_usb.rises == u0,
            "R7", "edges during power-down",
            real'(m_cpu.rises - c0 + m_bus.rises - b0 + m_ref.rises - r0 + m_usb.rises - u0), 0.0);
        all_low("R7", "levels during power-down");
        chk(out_en == 1'b1, "R1", "output enable during power-down", real'(out_en), 1.0);
        pwr_n = 1; #200;
        for (int k = 0; k < 8; k++) begin cpu_run = ~cpu_run; #(3.3 + 2.9 * k); end
        for (int k = 0; k < 8; k++) begin bus_run = ~bus_run; #(4.1 + 3.7 * k); end
        for (int k = 0; k < 8; k++) begin pwr_n = ~pwr_n;   #(5.3 + 4.3 * k); end
        #250;
    endtask

    // Shortest pulse widths since the last reset (R8) and group equality (R9).
    task automatic widths(input real hc, input real hb, input real hr, input real hu);
        chk(m_cpu.min_hi >= hc - 0.01 && m_cpu.min_lo >= hc - 0.01, "R8",
            "processor shortest pulse", (m_cpu.min_hi < m_cpu.min_lo) ? m_cpu.min_hi : m_cpu.min_lo, hc);
        chk(m_bus.min_hi >= hb - 0.01 && m_bus.min_lo >= hb - 0.01, "R8",
            "bus shortest pulse", (m_bus.min_hi < m_bus.min_lo) ? m_bus.min_hi : m_bus.min_lo, hb);
        chk(m_ref.min_hi >= hr - 0.01 && m_ref.min_lo >= hr - 0.01, "R8",
            "reference shortest pulse", (m_ref.min_hi < m_ref.min_lo) ? m_ref.min_hi : m_ref.min_lo, hr);
        chk(m_usb.min_hi >= hu - 0.01 && m_usb.min_lo >= hu - 0.01, "R8",
            "48 MHz shortest pulse", (m_usb.min_hi < m_usb.min_lo) ? m_usb.min_hi : m_usb.min_lo, hu);
        chk(grp_bad == 0, "R9", "lines within a group differ", real'(grp_bad), 0.0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        // Normal mode, lower rate code.
        enter_mode(2'b01);
        rates("R2", 400.0, 4.0, 8.0, 14.0, 10.0);
        stops(4.0, 8.0);
        widths(2.0, 4.0, 7.0, 5.0);
        // Normal mode, higher rate code.
        enter_mode(2'b10);
        rates("R2", 400.0, 4.0, 8.0, 14.0, 10.0);
        widths(2.0, 4.0, 7.0, 5.0);
        // Reference test mode.
        enter_mode(2'b11);
        rates("R4", 560.0, 28.0, 56.0, 14.0, 28.0);
        stops(28.0, 56.0);
        widths(14.0, 28.0, 7.0, 14.0);
        // High-impedance mode and power-down override of it.
        enter_mode(2'b00);
        chk(out_en == 1'b0, "R1", "output enable in select 00", real'(out_en), 0.0);
        pwr_n = 0; #20;
        chk(out_en == 1'b1, "R1", "power-down overrides select 00", real'(out_en), 1.0);
        pwr_n = 1; #20;
        done = 1;
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule